// File: doc/BRIEF.md
# 16-bit Timer with Filtered Capture

This block is a 16-bit up-counting timer with one capture channel and two compare channels. The count advances on enable pulses from a selectable source. The source is one of five fixed clock dividers taken from a free-running 10-bit prescaler, or a synchronized external pin counted on a chosen edge. A 3-bit code selects the source, and one code stops the counter. The capture channel stores the current count when a qualified edge appears on the capture pin. An optional noise filter accepts that edge only after the pin has held its new level for four further clocks.

Each compare channel watches for equality between the count and its own compare value. On a match it drives its output pin according to a 2-bit action code and raises its event flag. Compare channel A can also return the counter to zero, which gives a programmable period. Four event flags (overflow, capture, compare A, compare B) each have a mask bit, and a single interrupt output is the OR of the enabled flags. Software clears flags by writing ones. An interrupt-acknowledge pulse also clears the capture flag.

All configuration arrives on plain input ports and takes effect on the next clock.

Top module: `tmr16_capcmp`

## Requirements
- R1: `clk_sel` codes: 000 holds the count; 001, 010, 011, 100 and 101 advance it once every 1, 8, 64, 256 and 1024 clocks.
- R2: Code 111 advances the count once per rising edge of `ext_clk_pin`, and code 110 advances it once per falling edge. The pin passes through a two-stage synchronizer, and the count changes within four clocks of the pin change. The other edge has no effect.
- R3: When the count advances from 0xFFFF, it becomes 0x0000 and flag bit 0 (overflow) sets.
- R4: With the filter off, an edge on `cap_pin` is detected two clocks after the pin changes. In the detection cycle the count is copied to `cap_value`, and flag bit 1 sets on the following clock. `cap_rise_sel`=1 selects rising edges and 0 selects falling edges. An edge of the other polarity leaves `cap_value` and the flag unchanged.
- R5: With `cap_filt_en`=1, a detected edge is confirmed only if the synchronized pin keeps its new level on each of the next four clocks. The value stored is the count in the fourth sample cycle, which is the detection-cycle count plus 4 at divide-by-1. A pulse shorter than this is rejected.
- R6: A one-cycle `cap_ack` pulse clears flag bit 1. If a capture event falls in the same cycle as `cap_ack` or a write-one clear, the flag ends up set.
- R7: A match occurs when a count-advance pulse finds the count equal to the compare value. The match sets flag bit 2 for channel A or bit 3 for channel B on the next clock.
- R8: The action on a match sets the channel pin as follows: code 00 leaves it unchanged, 01 toggles it, 10 drives it to 0 and 11 drives it to 1. Both pins reset to 0.
- R9: With `clr_on_cmp_a`=1, a channel A match loads 0 into the count instead of incrementing it, so the count cycles through `cmp_a_val`+1 values.
- R10: Each 1 in `flag_clr` clears the matching flag on the next clock. `irq` is 1 exactly when some flag bit and its `irq_mask` bit are both 1. All flags reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sel | input | 3 | Count source select |
| ext_clk_pin | input | 1 | External count pin (asynchronous) |
| cap_pin | input | 1 | Capture pin (asynchronous) |
| cap_rise_sel | input | 1 | 1 = capture on rising edge, 0 = on falling edge |
| cap_filt_en | input | 1 | Enable the four-sample capture filter |
| cmp_a_val | input | 16 | Compare value, channel A |
| cmp_b_val | input | 16 | Compare value, channel B |
| pin_act_a | input | 2 | Match action, channel A |
| pin_act_b | input | 2 | Match action, channel B |
| clr_on_cmp_a | input | 1 | Clear the counter on a channel A match |
| flag_clr | input | 4 | Write-one-to-clear for the flags |
| cap_ack | input | 1 | Interrupt-acknowledge pulse for the capture flag |
| irq_mask | input | 4 | Per-flag interrupt enable |
| count | output | 16 | Current count |
| cap_value | output | 16 | Last captured count |
| cmp_pin_a | output | 1 | Channel A output pin |
| cmp_pin_b | output | 1 | Channel B output pin |
| flags | output | 4 | Event flags: 0 overflow, 1 capture, 2 compare A, 3 compare B |
| irq | output | 1 | Combined masked interrupt |

## Verification
Two events can compete for the capture flag in the same cycle: a confirmed capture sets it, and the acknowledge pulse clears it. The bench times a capture-pin change so that `cap_ack` is high in the exact cycle in which the synchronized edge is detected. It then requires the flag to read 1 on the next sample and `cap_value` to hold the count seen in that cycle. A second contention occurs when the count sits at 0xFFFF and channel A clears the counter on the same pulse. The ordering rule for that case is that a match with clear-on-match loads zero, and the bench checks this rule separately through the cycle length of the count.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  localparam int PRE_W  = 10;
  localparam int NFLAGS = 4;
  localparam int FLG_OVF  = 0;
  localparam int FLG_CAP  = 1;
  localparam int FLG_CMPA = 2;
  localparam int FLG_CMPB = 3;

  typedef enum logic [2:0] {
    CS_STOP     = 3'b000,
    CS_DIV1     = 3'b001,
    CS_DIV8     = 3'b010,
    CS_DIV64    = 3'b011,
    CS_DIV256   = 3'b100,
    CS_DIV1024  = 3'b101,
    CS_EXT_FALL = 3'b110,
    CS_EXT_RISE = 3'b111
  } clk_sel_e;

  typedef enum logic [1:0] {
    PA_HOLD   = 2'b00,
    PA_TOGGLE = 2'b01,
    PA_CLEAR  = 2'b10,
    PA_SET    = 2'b11
  } pin_act_e;

  // Divided enable: the low bits of the prescaler are all ones once per period.
  function automatic logic f_div_hit(input logic [2:0] sel, input logic [PRE_W-1:0] pre);
    case (sel)
      CS_DIV1:    f_div_hit = 1'b1;
      CS_DIV8:    f_div_hit = &pre[2:0];
      CS_DIV64:   f_div_hit = &pre[5:0];
      CS_DIV256:  f_div_hit = &pre[7:0];
      CS_DIV1024: f_div_hit = &pre[9:0];
      default:    f_div_hit = 1'b0;
    endcase
  endfunction

  // Next level of a compare pin when a match happens.
  function automatic logic f_pin_next(input logic [1:0] act, input logic cur);
    case (act)
      PA_TOGGLE: f_pin_next = ~cur;
      PA_CLEAR:  f_pin_next = 1'b0;
      PA_SET:    f_pin_next = 1'b1;
      default:   f_pin_next = cur;
    endcase
  endfunction

endpackage

// File: rtl/tmr16_prescale.sv
module tmr16_prescale
  import tmr16_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       ext_pin,
  output logic       tick
);

  logic [PRE_W-1:0]     pre_q;
  logic [SYNC_STAGES:0] ext_sh;
  logic                 ext_now, ext_prev, ext_rise, ext_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      ext_sh <= '0;
    end else begin
      pre_q  <= pre_q + PRE_W'(1);
      ext_sh <= {ext_sh[SYNC_STAGES-1:0], ext_pin};
    end
  end

  assign ext_now  = ext_sh[SYNC_STAGES-1];
  assign ext_prev = ext_sh[SYNC_STAGES];
  assign ext_rise = ext_now & ~ext_prev;
  assign ext_fall = ~ext_now & ext_prev;

  always_comb begin
    case (sel)
      CS_EXT_RISE: tick = ext_rise;
      CS_EXT_FALL: tick = ext_fall;
      default:     tick = f_div_hit(sel, pre_q);
    endcase
  end

  // R2: an external-mode tick always follows a synchronized transition
  p_ext_tick_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel[2:1] == 2'b11) |-> (ext_now != ext_prev));

endmodule

// File: rtl/tmr16_capture.sv
module tmr16_capture #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_N      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  input  logic filt_en,
  output logic cap_evt
);

  localparam int CNT_W = (FILT_N > 1) ? $clog2(FILT_N) : 1;

  logic [SYNC_STAGES:0] sh;
  logic                 now_lvl, prev_lvl, edge_hit, confirm;
  logic                 busy_q, lvl_q;
  logic [CNT_W-1:0]     cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_STAGES-1:0], pin};
  end

  assign now_lvl  = sh[SYNC_STAGES-1];
  assign prev_lvl = sh[SYNC_STAGES];
  assign edge_hit = rise_sel ? (now_lvl & ~prev_lvl) : (~now_lvl & prev_lvl);
  assign confirm  = busy_q && (now_lvl == lvl_q) && (cnt_q == CNT_W'(FILT_N - 1));
  assign cap_evt  = filt_en ? confirm : edge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      lvl_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (!filt_en) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (now_lvl != lvl_q || cnt_q == CNT_W'(FILT_N - 1)) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + CNT_W'(1);
      end
    end else if (edge_hit) begin
      busy_q <= 1'b1;
      lvl_q  <= now_lvl;
      cnt_q  <= '0;
    end
  end

  // R5: a filtered capture never fires without a pending qualification window
  p_filter_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && !busy_q) |-> !cap_evt);

  // R5: a level change during the window ends it without a capture
  p_filter_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && busy_q && now_lvl != lvl_q) |-> !cap_evt);

endmodule

// File: rtl/tmr16_compare.sv
module tmr16_compare
  import tmr16_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] cmp_val,
  input  logic [1:0]    act,
  output logic          match,
  output logic          pin
);

  logic pin_q;

  assign match = tick && (count == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pin_q <= 1'b0;
    else if (match) pin_q <= f_pin_next(act, pin_q);
  end

  assign pin = pin_q;

  p_pin_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (match && act == PA_SET) |=> pin_q);
  p_pin_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (match && act == PA_CLEAR) |=> !pin_q);
  p_pin_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (match && act == PA_TOGGLE) |=> pin_q != $past(pin_q));
  p_pin_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!match || act == PA_HOLD) |=> $stable(pin_q));

endmodule

// File: rtl/tmr16_capcmp.sv
module tmr16_capcmp
  import tmr16_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_N      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    clk_sel,
  input  logic          ext_clk_pin,
  input  logic          cap_pin,
  input  logic          cap_rise_sel,
  input  logic          cap_filt_en,
  input  logic [CW-1:0] cmp_a_val,
  input  logic [CW-1:0] cmp_b_val,
  input  logic [1:0]    pin_act_a,
  input  logic [1:0]    pin_act_b,
  input  logic          clr_on_cmp_a,
  input  logic [3:0]    flag_clr,
  input  logic          cap_ack,
  input  logic [3:0]    irq_mask,
  output logic [CW-1:0] count,
  output logic [CW-1:0] cap_value,
  output logic          cmp_pin_a,
  output logic          cmp_pin_b,
  output logic [3:0]    flags,
  output logic          irq
);

  localparam int NCH = 2;

  logic              tick;
  logic              cap_evt;
  logic              ovf_evt;
  logic [CW-1:0]     count_q, cap_q;
  logic [NFLAGS-1:0] flags_q, set_vec, clr_vec;
  logic [CW-1:0]     cmp_vals [NCH];
  logic [1:0]        acts     [NCH];
  logic [NCH-1:0]    match, pins;

  tmr16_prescale #(.SYNC_STAGES(SYNC_STAGES)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(clk_sel), .ext_pin(ext_clk_pin), .tick(tick)
  );

  tmr16_capture #(.SYNC_STAGES(SYNC_STAGES), .FILT_N(FILT_N)) u_cap (
    .clk(clk), .rst_n(rst_n), .pin(cap_pin), .rise_sel(cap_rise_sel),
    .filt_en(cap_filt_en), .cap_evt(cap_evt)
  );

  assign cmp_vals[0] = cmp_a_val;
  assign cmp_vals[1] = cmp_b_val;
  assign acts[0]     = pin_act_a;
  assign acts[1]     = pin_act_b;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_cmp
    tmr16_compare #(.CW(CW)) u_cmp (
      .clk(clk), .rst_n(rst_n), .tick(tick), .count(count_q),
      .cmp_val(cmp_vals[ch]), .act(acts[ch]), .match(match[ch]), .pin(pins[ch])
    );
  end

  assign ovf_evt = tick && (count_q == {CW{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (tick) begin
      if (clr_on_cmp_a && match[0]) count_q <= '0;
      else                          count_q <= count_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_q <= '0;
    else if (cap_evt) cap_q <= count_q;
  end

  always_comb begin
    set_vec           = '0;
    set_vec[FLG_OVF]  = ovf_evt;
    set_vec[FLG_CAP]  = cap_evt;
    set_vec[FLG_CMPA] = match[0];
    set_vec[FLG_CMPB] = match[1];
    clr_vec           = flag_clr;
    clr_vec[FLG_CAP]  = flag_clr[FLG_CAP] | cap_ack;
  end

  // setting wins over clearing in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_vec) | set_vec;
  end

  assign count     = count_q;
  assign cap_value = cap_q;
  assign cmp_pin_a = pins[0];
  assign cmp_pin_b = pins[1];
  assign flags     = flags_q;
  assign irq       = |(flags_q & irq_mask);

  p_stop_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == CS_STOP) |=> $stable(count_q));
  p_ovf_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (count_q == '0) && flags_q[FLG_OVF]);
  p_cap_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_q == $past(count_q)) && flags_q[FLG_CAP]);
  p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ack && !cap_evt) |=> !flags_q[FLG_CAP]);
  p_cmp_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (match[0] |=> flags_q[FLG_CMPA]) and (match[1] |=> flags_q[FLG_CMPB]));
  p_ctc_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_on_cmp_a && match[0]) |=> (count_q == '0));

endmodule

// File: tb/tmr16_capcmp_tb.sv
module tmr16_capcmp_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  clk_sel = 3'b000;
  logic        ext_clk_pin = 1'b0;
  logic        cap_pin = 1'b0;
  logic        cap_rise_sel = 1'b1;
  logic        cap_filt_en = 1'b0;
  logic [15:0] cmp_a_val = 16'hFFF0;
  logic [15:0] cmp_b_val = 16'hFFF0;
  logic [1:0]  pin_act_a = 2'b00;
  logic [1:0]  pin_act_b = 2'b00;
  logic        clr_on_cmp_a = 1'b0;
  logic [3:0]  flag_clr = 4'b0;
  logic        cap_ack = 1'b0;
  logic [3:0]  irq_mask = 4'b0;
  logic [15:0] count, cap_value;
  logic        cmp_pin_a, cmp_pin_b, irq;
  logic [3:0]  flags;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  tmr16_capcmp u_dut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_clk_pin(ext_clk_pin),
    .cap_pin(cap_pin), .cap_rise_sel(cap_rise_sel), .cap_filt_en(cap_filt_en),
    .cmp_a_val(cmp_a_val), .cmp_b_val(cmp_b_val), .pin_act_a(pin_act_a),
    .pin_act_b(pin_act_b), .clr_on_cmp_a(clr_on_cmp_a), .flag_clr(flag_clr),
    .cap_ack(cap_ack), .irq_mask(irq_mask), .count(count), .cap_value(cap_value),
    .cmp_pin_a(cmp_pin_a), .cmp_pin_b(cmp_pin_b), .flags(flags), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags();
    flag_clr = 4'hF; cyc(1); flag_clr = 4'h0;
  endtask

  task automatic wait_count(input logic [15:0] v, input string req);
    int guard = 0;
    while (count !== v && guard < 70000) begin cyc(1); guard++; end
    chk(req, "count reached target", 32'(count), 32'(v));
  endtask

  task automatic measure(output int per);
    logic [15:0] c;
    int g = 0;
    c = count;
    while (count == c && g < 3000) begin cyc(1); g++; end
    c = count; per = 0;
    while (count == c && per < 3000) begin cyc(1); per++; end
  endtask

  task automatic t_reset();
    cyc(3); rst_n = 1'b1;
    chk("R10", "flags after reset", 32'(flags), 0);
    chk("R1", "count after reset", 32'(count), 0);
    chk("R8", "pins after reset", {cmp_pin_a, cmp_pin_b}, 0);
    chk("R10", "irq after reset", 32'(irq), 0);
  endtask

  task automatic t_stop();
    cyc(20);
    chk("R1", "stopped count holds", 32'(count), 0);
  endtask

  task automatic t_dividers();
    int p;
    clk_sel = 3'b001; measure(p); chk("R1", "div1 period", p, 1);
    clk_sel = 3'b010; measure(p); chk("R1", "div8 period", p, 8);
    clk_sel = 3'b011; measure(p); chk("R1", "div64 period", p, 64);
    clk_sel = 3'b101; measure(p); chk("R1", "div1024 period", p, 1024);
  endtask

  task automatic t_external();
    logic [15:0] c0;
    clk_sel = 3'b111; cyc(2); c0 = count;
    ext_clk_pin = 1'b1; cyc(6); chk("R2", "rising mode counts rise", 32'(count), 32'(c0 + 16'd1));
    ext_clk_pin = 1'b0; cyc(6); chk("R2", "rising mode ignores fall", 32'(count), 32'(c0 + 16'd1));
    clk_sel = 3'b110; cyc(2);
    ext_clk_pin = 1'b1; cyc(6); chk("R2", "falling mode ignores rise", 32'(count), 32'(c0 + 16'd1));
    ext_clk_pin = 1'b0; cyc(6); chk("R2", "falling mode counts fall", 32'(count), 32'(c0 + 16'd2));
  endtask

  task automatic t_ctc();
    logic [15:0] top;
    int n = 0;
    clk_sel = 3'b001; cyc(1);
    top = count + 16'd30;
    cmp_a_val = top; clr_on_cmp_a = 1'b1;
    wait_count(top, "R9");
    cyc(1);
    chk("R9", "count cleared after match", 32'(count), 0);
    chk("R7", "compare A flag", 32'(flags[2]), 1);
    while (count != 16'd0 || n == 0) begin cyc(1); n++; if (n > 100) break; end
    chk("R9", "cleared-count cycle length", n, 32'(top) + 1);
    clr_on_cmp_a = 1'b0; cmp_a_val = 16'hFFF0;
  endtask

  task automatic t_overflow();
    clk_sel = 3'b001; clear_flags();
    wait_count(16'hFFFF, "R3");
    chk("R3", "overflow flag before wrap", 32'(flags[0]), 0);
    cyc(1);
    chk("R3", "count wraps to zero", 32'(count), 0);
    chk("R3", "overflow flag set", 32'(flags[0]), 1);
  endtask

  task automatic t_capture_plain();
    logic [15:0] e, held;
    cap_filt_en = 1'b0; cap_rise_sel = 1'b1; cap_pin = 1'b0; cyc(4); clear_flags();
    cap_pin = 1'b1; cyc(2); e = count; cyc(1);
    chk("R4", "rising capture value", 32'(cap_value), 32'(e));
    chk("R4", "capture flag set", 32'(flags[1]), 1);
    cap_rise_sel = 1'b0; clear_flags(); held = cap_value;
    cap_pin = 1'b0; cyc(2); e = count; cyc(1);
    chk("R4", "falling capture value", 32'(cap_value), 32'(e));
    clear_flags(); held = cap_value;
    cap_pin = 1'b1; cyc(6);
    chk("R4", "wrong edge leaves flag", 32'(flags[1]), 0);
    chk("R4", "wrong edge leaves value", 32'(cap_value), 32'(held));
  endtask

  task automatic t_capture_filter();
    logic [15:0] e, held;
    cap_rise_sel = 1'b1; cap_filt_en = 1'b1; cap_pin = 1'b0; cyc(8); clear_flags();
    cap_pin = 1'b1; cyc(2); e = count; cyc(4);
    chk("R5", "no flag before confirm", 32'(flags[1]), 0);
    cyc(1);
    chk("R5", "filtered flag set", 32'(flags[1]), 1);
    chk("R5", "filtered capture value", 32'(cap_value), 32'(e + 16'd4));
    cap_pin = 1'b0; cyc(8); clear_flags(); held = cap_value;
    cap_pin = 1'b1; cyc(2); cap_pin = 1'b0; cyc(10);
    chk("R5", "glitch rejected flag", 32'(flags[1]), 0);
    chk("R5", "glitch rejected value", 32'(cap_value), 32'(held));
    cap_filt_en = 1'b0; cyc(2);
    cap_pin = 1'b1; cyc(2); cap_pin = 1'b0; cyc(6);
    chk("R4", "unfiltered glitch captured", 32'(flags[1]), 1);
  endtask

  task automatic t_ack();
    logic [15:0] e;
    cap_ack = 1'b1; cyc(1); cap_ack = 1'b0;
    chk("R6", "ack clears capture flag", 32'(flags[1]), 0);
    cap_pin = 1'b1; cyc(6);
    flag_clr = 4'b0010; cyc(1); flag_clr = 4'b0;
    chk("R6", "write-one clears capture flag", 32'(flags[1]), 0);
    cap_pin = 1'b0; cyc(6);
    cap_pin = 1'b1; cyc(2); e = count; cap_ack = 1'b1; cyc(1); cap_ack = 1'b0;
    chk("R6", "set wins over ack", 32'(flags[1]), 1);
    chk("R6", "value on collision", 32'(cap_value), 32'(e));
    cap_pin = 1'b0; cyc(4);
  endtask

  task automatic hit(input bit chan_b);
    logic [15:0] t;
    t = count + 16'd20;
    if (chan_b) cmp_b_val = t; else cmp_a_val = t;
    wait_count(t, "R7");
    cyc(1);
  endtask

  task automatic t_compare();
    clk_sel = 3'b001; clear_flags();
    pin_act_a = 2'b11; hit(1'b0);
    chk("R8", "set action", 32'(cmp_pin_a), 1);
    chk("R7", "compare A flag", 32'(flags[2]), 1);
    pin_act_a = 2'b01; hit(1'b0);
    chk("R8", "toggle to 0", 32'(cmp_pin_a), 0);
    hit(1'b0);
    chk("R8", "toggle to 1", 32'(cmp_pin_a), 1);
    pin_act_a = 2'b00; hit(1'b0);
    chk("R8", "hold action", 32'(cmp_pin_a), 1);
    pin_act_b = 2'b11; hit(1'b1);
    chk("R8", "B set action", 32'(cmp_pin_b), 1);
    chk("R7", "compare B flag", 32'(flags[3]), 1);
    pin_act_b = 2'b10; hit(1'b1);
    chk("R8", "B clear action", 32'(cmp_pin_b), 0);
  endtask

  task automatic t_irq();
    clk_sel = 3'b000; cyc(2);
    irq_mask = 4'b0000; cyc(1);
    chk("R10", "masked irq low", 32'(irq), 0);
    irq_mask = 4'b0100; cyc(1);
    chk("R10", "enabled flag raises irq", 32'(irq), 1);
    flag_clr = 4'b0100; cyc(1); flag_clr = 4'b0;
    chk("R10", "write-one clears compare A", 32'(flags[2]), 0);
    chk("R10", "other flag untouched", 32'(flags[3]), 1);
    chk("R10", "irq drops", 32'(irq), 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog all: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_stop();
    t_dividers();
    t_external();
    t_ctc();
    t_overflow();
    t_capture_plain();
    t_capture_filter();
    t_ack();
    t_compare();
    t_irq();
    summary();
    $finish;
  end

endmodule